// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps events on up to four external input lines. A free-running timestamp counter advances once every (prescaler + 1) clock cycles. Each channel watches its own input pin through a two-flop synchroniser. When the edge kind picked for that channel appears, the channel copies the current timestamp into its captured-value register and raises a sticky status bit.

Software drives the block through a simple word-addressed register port. It sets the prescaler and the global capture enable, picks an edge mode for each channel, enables the channel interrupts, reads back the captured timestamps, and clears status bits by writing a separate acknowledge register. A single interrupt line is high while any enabled channel has its status bit set. The interval between two captures on one channel, counted in prescaled ticks, gives the period or pulse width of the input signal.

Top module: `edge_capture_unit`

## Requirements
- R1: After a synchronous reset, every readable register reads zero and `irq` is low.
- R2: The register port decodes these byte addresses. Control is at 0x50, with the prescaler in bits 8:4 and the capture enable in bit 10. The edge mode of channel c is at 0x30+4c, bits 1:0. Interrupt enables are at 0x54 and status is at 0x58, with channel c in bit c+1 of each. The captured value of channel c is at 0x10+4c. Writing 0x5C acknowledges. Unused bits read zero.
- R3: Edge mode 1 captures on rising edges only. The status bit and the captured value become visible after the third rising clock edge that samples the new pin level.
- R4: Edge mode 2 captures on falling edges only.
- R5: Edge mode 3 captures on both rising and falling edges.
- R6: Edge mode 0 never captures.
- R7: While the capture enable is clear, an edge causes no capture: status and captured value stay unchanged.
- R8: The timestamp advances by one every (prescaler + 1) clock cycles. Two captures taken N·(prescaler+1) cycles apart therefore differ by exactly N.
- R9: A status bit stays set until it is acknowledged. A write to 0x5C clears every channel whose bit (c+1) is 1 in the written data. Bit 0 and bits 8:5 have no effect.
- R10: `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R11: When a capture and an acknowledge of the same channel fall in the same clock cycle, the status bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe, acts at the rising clock edge |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational from `bus_addr` |
| cap_pin | input | NCH (4) | Asynchronous capture inputs, one per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
A pin change applied before clock edge k is sampled at k. It reaches the second synchroniser flop at k+1 and updates status, captured value and `irq` at k+2. Register writes take effect at the edge that follows the strobe, and reads are combinational.

The latency test samples status after edges k, k+1 and k+2 and expects it set only at the last of these. The collision test places an acknowledge write exactly on edge k+2. The edge-mode vector table and the other checks wait five cycles after a stimulus before they sample. They always sample on the falling clock edge, away from the active edge.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    // Edge selection per channel: bit 0 = rising, bit 1 = falling
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    // Synchronised edge events of one input line
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    // Register byte offsets
    localparam int OFS_VAL  = 'h10;   // captured timestamp, per channel
    localparam int OFS_MODE = 'h30;   // edge mode, per channel
    localparam int OFS_CTRL = 'h50;   // prescaler and capture enable
    localparam int OFS_IEN  = 'h54;   // interrupt enables
    localparam int OFS_ISTS = 'h58;   // interrupt status
    localparam int OFS_ACK  = 'h5C;   // write-to-clear

    localparam int CTRL_PSC_LSB = 4;
    localparam int CTRL_EN_BIT  = 10;
    localparam int IRQ_LSB      = 1;  // channel c sits at bit c+1
    localparam int MAX_CHANNELS = 4;

    function automatic int slot_addr(input int base, input int chan);
        return base + 4 * chan;
    endfunction

    function automatic logic edge_qualifies(input edge_mode_e m, input edge_ev_t ev);
        return (m[0] & ev.rise) | (m[1] & ev.fall);
    endfunction

endpackage

// File: rtl/ecap_sync.sv
module ecap_sync
    import ecap_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCH-1:0]            pin_i,
    output edge_ev_t [NCH-1:0]        ev_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[c];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign ev_o[c].rise = sync_q & ~prev_q;
        assign ev_o[c].fall = ~sync_q & prev_q;
    end

endmodule

// File: rtl/ecap_timebase.sv
module ecap_timebase #(
    parameter int TS_W  = 32,
    parameter int PSC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PSC_W-1:0]  psc_i,
    output logic [TS_W-1:0]   ts_o
);

    logic [PSC_W-1:0] div_q;
    logic [TS_W-1:0]  ts_q;
    logic             tick;

    // A lowered prescaler ends the current interval at once
    assign tick = (div_q >= psc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            ts_q  <= '0;
        end else if (tick) begin
            div_q <= '0;
            ts_q  <= ts_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign ts_o = ts_q;

    AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ts_q == $past(ts_q)); // R8
    AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> ts_q == $past(ts_q) + 1'b1); // R8

endmodule

// File: rtl/ecap_regs.sv
module ecap_regs
    import ecap_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TS_W  = 32,
    parameter int PSC_W = 5,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        wdata_i,
    output logic [DW-1:0]        rdata_o,
    input  edge_ev_t [NCH-1:0]   ev_i,
    input  logic [TS_W-1:0]      ts_i,
    output logic [PSC_W-1:0]     psc_o,
    output logic                 irq_o
);

    localparam int AI = 32;

    logic [AI-1:0]     a;
    logic              ctrl_we, ien_we, ack_we;
    logic [PSC_W-1:0]  psc_q;
    logic              en_q;
    logic [NCH-1:0]    ien_q;
    logic [NCH-1:0]    sts_q;
    logic [NCH-1:0]    hit;
    logic [NCH-1:0]    clr;
    logic [NCH-1:0]    mode_we;
    edge_mode_e        mode_q [NCH];
    logic [TS_W-1:0]   val_q  [NCH];
    logic              unused_bits;

    assign a       = AI'(addr_i);
    assign ctrl_we = we_i && (a == AI'(OFS_CTRL));
    assign ien_we  = we_i && (a == AI'(OFS_IEN));
    assign ack_we  = we_i && (a == AI'(OFS_ACK));
    assign clr     = ack_we ? wdata_i[IRQ_LSB +: NCH] : '0;
    assign unused_bits = ^wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q <= '0;
            en_q  <= 1'b0;
            ien_q <= '0;
        end else begin
            if (ctrl_we) begin
                psc_q <= wdata_i[CTRL_PSC_LSB +: PSC_W];
                en_q  <= wdata_i[CTRL_EN_BIT];
            end
            if (ien_we) begin
                ien_q <= wdata_i[IRQ_LSB +: NCH];
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign mode_we[c] = we_i && (a == AI'(slot_addr(OFS_MODE, c)));
        assign hit[c]     = en_q && edge_qualifies(mode_q[c], ev_i[c]);

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[c] <= EDGE_OFF;
                val_q[c]  <= '0;
                sts_q[c]  <= 1'b0;
            end else begin
                if (mode_we[c]) begin
                    mode_q[c] <= edge_mode_e'(wdata_i[1:0]);
                end
                if (hit[c]) begin
                    val_q[c] <= ts_i;
                end
                // a new capture outranks a simultaneous acknowledge
                sts_q[c] <= hit[c] | (sts_q[c] & ~clr[c]);
            end
        end

        AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            !en_q |=> $stable(val_q[c])); // R7
        AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (sts_q[c] && !(ack_we && wdata_i[IRQ_LSB + c])) |=> sts_q[c]); // R9
        AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
            (mode_q[c] == EDGE_OFF && !sts_q[c]) |=> !sts_q[c]); // R6
    end

    always_comb begin
        rdata_o = '0;
        if (a == AI'(OFS_CTRL)) begin
            rdata_o[CTRL_PSC_LSB +: PSC_W] = psc_q;
            rdata_o[CTRL_EN_BIT]           = en_q;
        end
        if (a == AI'(OFS_IEN)) begin
            rdata_o[IRQ_LSB +: NCH] = ien_q;
        end
        if (a == AI'(OFS_ISTS)) begin
            rdata_o[IRQ_LSB +: NCH] = sts_q;
        end
        for (int c = 0; c < NCH; c++) begin
            if (a == AI'(slot_addr(OFS_VAL, c))) begin
                rdata_o[TS_W-1:0] = val_q[c];
            end
            if (a == AI'(slot_addr(OFS_MODE, c))) begin
                rdata_o[1:0] = mode_q[c];
            end
        end
    end

    assign psc_o = psc_q;
    assign irq_o = |(sts_q & ien_q);

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int NCH   = 4,   // 1..MAX_CHANNELS
    parameter int TS_W  = 32,  // must not exceed DW
    parameter int PSC_W = 5,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NCH-1:0]  cap_pin,
    output logic            irq
);

    edge_ev_t [NCH-1:0] ev;
    logic [TS_W-1:0]    ts;
    logic [PSC_W-1:0]   psc;

    ecap_sync #(.NCH(NCH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (cap_pin),
        .ev_o  (ev)
    );

    ecap_timebase #(.TS_W(TS_W), .PSC_W(PSC_W)) u_tb (
        .clk   (clk),
        .rst   (rst),
        .psc_i (psc),
        .ts_o  (ts)
    );

    ecap_regs #(
        .NCH(NCH), .TS_W(TS_W), .PSC_W(PSC_W), .AW(AW), .DW(DW)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (bus_we),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .rdata_o (bus_rdata),
        .ev_i    (ev),
        .ts_i    (ts),
        .psc_o   (psc),
        .irq_o   (irq)
    );

    AST_IRQ_LOW_IN_RESET: assert property (@(posedge clk)
        rst |=> !irq); // R1

endmodule

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;
    import ecap_pkg::*;

    localparam int NCH = 4, TS_W = 32, PSC_W = 5, AW = 8, DW = 32;
    localparam int A_CTRL = 'h50, A_IEN = 'h54, A_STS = 'h58, A_ACK = 'h5C;
    localparam int A_MODE0 = 'h30, A_MODE1 = 'h34, A_VAL1 = 'h14, A_VAL0 = 'h10;
    localparam logic [DW-1:0] EN = 32'h400;

    typedef struct packed {
        logic [1:0] mode;
        logic       dir;   // 1 = rising stimulus, 0 = falling
        logic       hit;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd1, 1'b1, 1'b1}, '{2'd1, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b0}, '{2'd2, 1'b0, 1'b1},
        '{2'd3, 1'b1, 1'b1}, '{2'd3, 1'b0, 1'b1},
        '{2'd0, 1'b1, 1'b0}, '{2'd0, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1, we = 1'b0, irq;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wdata = '0, rdata, v, v1, v2;
    logic [NCH-1:0] pin = '0;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    edge_capture_unit #(.NCH(NCH), .TS_W(TS_W), .PSC_W(PSC_W), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .cap_pin(pin), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk); addr = AW'(a); #0.5; d = rdata;
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd1: return "R3 rising";
            2'd2: return "R4 falling";
            2'd3: return "R5 both";
            default: return "R6 off";
        endcase
    endfunction

    // two captures on channel 1 in both-edge mode, gap clock cycles apart
    task automatic measure(input int gap, output logic [DW-1:0] diff);
        @(negedge clk); pin[1] = ~pin[1];
        repeat (5) @(negedge clk);
        addr = AW'(A_VAL1); #0.5; v1 = rdata;
        repeat (gap - 5) @(negedge clk);
        pin[1] = ~pin[1];
        repeat (5) @(negedge clk);
        addr = AW'(A_VAL1); #0.5; v2 = rdata;
        diff = v2 - v1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_IEN, v);   check("R1 ien", v, 0);
        rd(A_STS, v);   check("R1 sts", v, 0);
        rd(A_VAL0, v);  check("R1 val0", v, 0);
        rd(A_MODE0, v); check("R1 mode0", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2: register field readback and masking
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R2 ctrl", v, 32'h0000_05F0);
        wr(A_MODE1, 32'hFF);       rd(A_MODE1, v); check("R2 mode", v, 32'h3);
        wr(A_IEN, 32'hFF);         rd(A_IEN, v);   check("R2 ien", v, 32'h1E);
        wr(A_MODE1, 0); wr(A_IEN, 0);
        wr(A_CTRL, EN);

        // R3..R6: edge-mode vector table on channel 0
        for (int i = 0; i < 8; i++) begin
            wr(A_MODE0, 0);
            @(negedge clk); pin[0] = ~VECS[i].dir;
            repeat (5) @(negedge clk);
            wr(A_ACK, 32'h1FF);
            wr(A_MODE0, 32'(VECS[i].mode));
            @(negedge clk); pin[0] = VECS[i].dir;
            repeat (5) @(negedge clk);
            rd(A_STS, v);
            check(mode_tag(VECS[i].mode), v, VECS[i].hit ? 32'h2 : 32'h0);
        end

        // R3: exact latency of a rising capture
        wr(A_MODE0, 0);
        @(negedge clk); pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        wr(A_ACK, 32'h1FF);
        wr(A_MODE0, 32'd1);
        addr = AW'(A_STS);
        @(negedge clk); pin[0] = 1'b1;
        @(negedge clk); #0.5; check("R3 latency edge k", rdata, 0);
        @(negedge clk); #0.5; check("R3 latency edge k+1", rdata, 0);
        @(negedge clk); #0.5; check("R3 latency edge k+2", rdata, 32'h2);

        // R8: timestamp spacing with two prescaler settings
        wr(A_MODE1, 32'd3);
        measure(10, v); check("R8 prescaler 0", v, 32'd10);
        wr(A_CTRL, EN | 32'h30);
        measure(12, v); check("R8 prescaler 3", v, 32'd3);
        wr(A_CTRL, EN);

        // R7: capture disabled
        wr(A_ACK, 32'h1FF);
        wr(A_CTRL, 0);
        rd(A_VAL1, v1);
        @(negedge clk); pin[1] = ~pin[1];
        repeat (5) @(negedge clk);
        rd(A_VAL1, v); check("R7 value held", v, v1);
        rd(A_STS, v);  check("R7 status clear", v, 0);
        wr(A_CTRL, EN);

        // R10 and R9: interrupt masking and selective acknowledge
        wr(A_IEN, 32'h2);
        wr(A_MODE1, 32'd3);
        wr(A_MODE0, 32'd3);
        @(negedge clk); pin[1] = ~pin[1];
        repeat (5) @(negedge clk);
        rd(A_STS, v); check("R10 sts ch1", v, 32'h4);
        check("R10 irq masked", 32'(irq), 0);
        @(negedge clk); pin[0] = ~pin[0];
        repeat (5) @(negedge clk);
        rd(A_STS, v); check("R9 sts both", v, 32'h6);
        check("R10 irq enabled", 32'(irq), 1);
        wr(A_ACK, 32'h1E5);
        rd(A_STS, v); check("R9 ack ch1 only", v, 32'h2);
        check("R10 irq after ack", 32'(irq), 1);
        wr(A_ACK, 32'h1E1);
        rd(A_STS, v); check("R9 non-channel bits ignored", v, 32'h2);
        wr(A_ACK, 32'h2);
        rd(A_STS, v); check("R9 ack ch0", v, 0);
        check("R10 irq low", 32'(irq), 0);

        // R11: capture and acknowledge on the same edge
        @(negedge clk); pin[0] = ~pin[0];
        @(negedge clk);
        @(negedge clk); we = 1'b1; addr = AW'(A_ACK); wdata = 32'h2;
        @(negedge clk); we = 1'b0;
        rd(A_STS, v); check("R11 set wins", v, 32'h2);
        wr(A_ACK, 32'h2);
        rd(A_STS, v); check("R11 cleared later", v, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule